// File: doc/BRIEF.md
# Video Stream Receiver with Field Detection

This block receives an 8-bit multiplexed 4:2:2 luma/chroma byte stream together with a vertical reference, a horizontal reference, an active-video qualifier and a data-valid qualifier, all sampled on one pixel clock. It tracks the position in the picture with a horizontal clock counter and a line counter, works out the field polarity, and splits the byte stream into luma and chroma pixels.

Every input goes through one register stage first. Edge detection runs on those registered copies. The horizontal counter restarts only on the horizontal reference's leading edge, and the line counter only on the vertical reference's leading edge. Nothing in the block depends on a fixed line length or blanking width, and no sync information is taken from data values.

A byte counts as picture data only when both qualifiers are high. Tying the data-valid input high gives a line-locked source with no gaps. Each completed group of four bytes is emitted as two pixels on consecutive cycles. The two pixels share one Cb and one Cr, and each pixel has its own valid strobe.

Top module: `vrx_top`

## Requirements
- R1: While `rst` is high, and in the cycle after it, every output is zero and `pix_vld_o`, `line_start_o` and `field_start_o` are low.
- R2: A rising edge on `href_i` makes `line_start_o` pulse for one cycle with `h_cnt_o` equal to 0. The pulse appears two clock edges after the rising edge is presented. A falling edge of `vact_i` does not reset `h_cnt_o`.
- R3: `h_cnt_o` goes up by one on every clock between horizontal leading edges. It has no built-in line length and saturates at 2^HCW-1.
- R4: A rising edge on `vref_i` clears `v_cnt_o` to 0, two edges later. Each later rising edge on `href_i` adds one to it.
- R5: When `vref_i` falls, `field_odd_o` takes the level `href_i` had in that same cycle (1 = odd, 0 = even), and `field_start_o` pulses for one cycle. At all other times `field_odd_o` holds its value.
- R6: A byte is accepted only in a cycle where `vact_i` and `dval_i` are both high. Bytes in any other cycle have no effect on the pixel outputs.
- R7: Accepted bytes are taken in the order Cb, Y0, Cr, Y1, repeating. The order restarts at Cb with the first byte accepted after `vact_i` rises, so a short line cannot shift the byte order of the next line.
- R8: Once Y1 is accepted, the next edge shows `pix_vld_o`=1, `pix_odd_o`=0, `y_o`=Y0. The edge after that shows `pix_vld_o`=1, `pix_odd_o`=1, `y_o`=Y1. `cb_o`, `cr_o`, `y0_o` and `y1_o` keep the group's values during both cycles.
- R9: All byte values, including 0x00, 0xFF and luma below 0x10, pass through as picture data and leave `v_cnt_o` and the markers unchanged.
- R10: With `dval_i` held high, back-to-back bytes are accepted on every cycle where `vact_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_data_i | input | DW | Multiplexed Cb/Y/Cr/Y byte stream |
| vref_i | input | 1 | Vertical reference |
| href_i | input | 1 | Horizontal reference |
| vact_i | input | 1 | Active-video qualifier |
| dval_i | input | 1 | Data-valid qualifier |
| y0_o | output | DW | First luma of the current pair |
| y1_o | output | DW | Second luma of the current pair |
| y_o | output | DW | Luma of the pixel being strobed |
| cb_o | output | DW | Shared Cb of the current pair |
| cr_o | output | DW | Shared Cr of the current pair |
| pix_vld_o | output | 1 | One-cycle strobe per output pixel |
| pix_odd_o | output | 1 | High when the strobed pixel is the second of its pair |
| line_start_o | output | 1 | One-cycle pulse on each horizontal leading edge |
| field_start_o | output | 1 | One-cycle pulse on each vertical trailing edge |
| field_odd_o | output | 1 | Field polarity, 1 = odd |
| h_cnt_o | output | HCW | Clocks since the last horizontal leading edge |
| v_cnt_o | output | VCW | Lines since the last vertical leading edge |

## Verification
The demultiplexer is driven with four input patterns. A gapless line-locked burst shows that accepting a byte on every cycle works. A burst with gaps, where `dval_i` drops between bytes, separates a design that gates on both qualifiers from one that gates on only one. Bytes sent while `vact_i` is low must also be ignored. A truncated line followed by a full one shows whether the byte order restarts when `vact_i` rises. The field tests fire the vertical trailing edge with `href_i` both high and low, so a design that samples at the leading edge is caught. The counter tests drop `vact_i` in mid-line and run past the counter width, to check reset sources and saturation.

// File: rtl/vrx_pkg.sv
package vrx_pkg;
  typedef enum logic [1:0] {
    PH_CB = 2'd0,
    PH_Y0 = 2'd1,
    PH_CR = 2'd2,
    PH_Y1 = 2'd3
  } byte_phase_e;

  localparam int unsigned NUM_CTL = 4;
  localparam int unsigned CTL_VREF = 0;
  localparam int unsigned CTL_HREF = 1;
  localparam int unsigned CTL_VACT = 2;
  localparam int unsigned CTL_DVAL = 3;
endpackage

// File: rtl/vrx_in_stage.sv
module vrx_in_stage
  import vrx_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DW-1:0]      data_i,
  input  logic [NUM_CTL-1:0] ctl_i,
  output logic [DW-1:0]      data_q,
  output logic [NUM_CTL-1:0] lvl_q,
  output logic [NUM_CTL-1:0] rise_q,
  output logic [NUM_CTL-1:0] fall_q
);
  logic [NUM_CTL-1:0] cur_q;
  logic [NUM_CTL-1:0] prv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= '0;
      prv_q  <= '0;
      data_q <= '0;
    end else begin
      cur_q  <= ctl_i;
      prv_q  <= cur_q;
      data_q <= data_i;
    end
  end

  // One edge detector per control line
  for (genvar g = 0; g < NUM_CTL; g++) begin : g_edge
    assign rise_q[g] = cur_q[g] & ~prv_q[g];
    assign fall_q[g] = ~cur_q[g] & prv_q[g];
  end

  assign lvl_q = cur_q;
endmodule

// File: rtl/vrx_timing.sv
module vrx_timing #(
  parameter int unsigned HCW = 12,
  parameter int unsigned VCW = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           href_lvl,
  input  logic           href_rise,
  input  logic           vref_rise,
  input  logic           vref_fall,
  output logic [HCW-1:0] h_cnt_o,
  output logic [VCW-1:0] v_cnt_o,
  output logic           line_start_o,
  output logic           field_start_o,
  output logic           field_odd_o
);
  localparam logic [HCW-1:0] HMAX = {HCW{1'b1}};
  localparam logic [VCW-1:0] VMAX = {VCW{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      h_cnt_o       <= '0;
      v_cnt_o       <= '0;
      line_start_o  <= 1'b0;
      field_start_o <= 1'b0;
      field_odd_o   <= 1'b0;
    end else begin
      line_start_o  <= href_rise;
      field_start_o <= vref_fall;

      if (href_rise)
        h_cnt_o <= '0;
      else if (h_cnt_o != HMAX)
        h_cnt_o <= h_cnt_o + 1'b1;

      if (vref_rise)
        v_cnt_o <= '0;
      else if (href_rise && (v_cnt_o != VMAX))
        v_cnt_o <= v_cnt_o + 1'b1;

      // polarity taken at the trailing edge of the vertical reference
      if (vref_fall)
        field_odd_o <= href_lvl;
    end
  end
endmodule

// File: rtl/vrx_demux.sv
module vrx_demux
  import vrx_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] data_q,
  input  logic          vact_lvl,
  input  logic          accept,
  output logic [DW-1:0] y0_o,
  output logic [DW-1:0] y1_o,
  output logic [DW-1:0] y_o,
  output logic [DW-1:0] cb_o,
  output logic [DW-1:0] cr_o,
  output logic          pix_vld_o,
  output logic          pix_odd_o
);
  byte_phase_e   phase_q;
  logic [DW-1:0] cb_q, y0_q, cr_q;
  logic          pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_CB;
      cb_q      <= '0;
      y0_q      <= '0;
      cr_q      <= '0;
      pend_q    <= 1'b0;
      y0_o      <= '0;
      y1_o      <= '0;
      y_o       <= '0;
      cb_o      <= '0;
      cr_o      <= '0;
      pix_vld_o <= 1'b0;
      pix_odd_o <= 1'b0;
    end else begin
      pix_vld_o <= 1'b0;

      // second pixel of a finished pair
      if (pend_q) begin
        pix_vld_o <= 1'b1;
        pix_odd_o <= 1'b1;
        y_o       <= y1_o;
        pend_q    <= 1'b0;
      end

      if (!vact_lvl) begin
        phase_q <= PH_CB;
      end else if (accept) begin
        unique case (phase_q)
          PH_CB: begin
            cb_q    <= data_q;
            phase_q <= PH_Y0;
          end
          PH_Y0: begin
            y0_q    <= data_q;
            phase_q <= PH_CR;
          end
          PH_CR: begin
            cr_q    <= data_q;
            phase_q <= PH_Y1;
          end
          PH_Y1: begin
            phase_q   <= PH_CB;
            y0_o      <= y0_q;
            y1_o      <= data_q;
            cb_o      <= cb_q;
            cr_o      <= cr_q;
            y_o       <= y0_q;
            pix_vld_o <= 1'b1;
            pix_odd_o <= 1'b0;
            pend_q    <= 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/vrx_top.sv
module vrx_top
  import vrx_pkg::*;
#(
  parameter int unsigned DW  = 8,
  parameter int unsigned HCW = 12,
  parameter int unsigned VCW = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [DW-1:0]  pix_data_i,
  input  logic           vref_i,
  input  logic           href_i,
  input  logic           vact_i,
  input  logic           dval_i,
  output logic [DW-1:0]  y0_o,
  output logic [DW-1:0]  y1_o,
  output logic [DW-1:0]  y_o,
  output logic [DW-1:0]  cb_o,
  output logic [DW-1:0]  cr_o,
  output logic           pix_vld_o,
  output logic           pix_odd_o,
  output logic           line_start_o,
  output logic           field_start_o,
  output logic           field_odd_o,
  output logic [HCW-1:0] h_cnt_o,
  output logic [VCW-1:0] v_cnt_o
);
  logic [NUM_CTL-1:0] ctl_in;
  logic [NUM_CTL-1:0] lvl, rise, fall;
  logic [DW-1:0]      data_q;
  logic               accept;

  always_comb begin
    ctl_in           = '0;
    ctl_in[CTL_VREF] = vref_i;
    ctl_in[CTL_HREF] = href_i;
    ctl_in[CTL_VACT] = vact_i;
    ctl_in[CTL_DVAL] = dval_i;
  end

  vrx_in_stage #(.DW(DW)) u_in (
    .clk    (clk),
    .rst    (rst),
    .data_i (pix_data_i),
    .ctl_i  (ctl_in),
    .data_q (data_q),
    .lvl_q  (lvl),
    .rise_q (rise),
    .fall_q (fall)
  );

  assign accept = lvl[CTL_VACT] & lvl[CTL_DVAL];

  vrx_timing #(.HCW(HCW), .VCW(VCW)) u_tim (
    .clk           (clk),
    .rst           (rst),
    .href_lvl      (lvl[CTL_HREF]),
    .href_rise     (rise[CTL_HREF]),
    .vref_rise     (rise[CTL_VREF]),
    .vref_fall     (fall[CTL_VREF]),
    .h_cnt_o       (h_cnt_o),
    .v_cnt_o       (v_cnt_o),
    .line_start_o  (line_start_o),
    .field_start_o (field_start_o),
    .field_odd_o   (field_odd_o)
  );

  vrx_demux #(.DW(DW)) u_dmx (
    .clk       (clk),
    .rst       (rst),
    .data_q    (data_q),
    .vact_lvl  (lvl[CTL_VACT]),
    .accept    (accept),
    .y0_o      (y0_o),
    .y1_o      (y1_o),
    .y_o       (y_o),
    .cb_o      (cb_o),
    .cr_o      (cr_o),
    .pix_vld_o (pix_vld_o),
    .pix_odd_o (pix_odd_o)
  );
endmodule

// File: rtl/vrx_chk.sv
module vrx_chk #(
  parameter int unsigned DW  = 8,
  parameter int unsigned HCW = 12
) (
  input logic           clk,
  input logic           rst,
  input logic [DW-1:0]  y1_o,
  input logic [DW-1:0]  cb_o,
  input logic [DW-1:0]  cr_o,
  input logic           pix_vld_o,
  input logic           pix_odd_o,
  input logic           line_start_o,
  input logic           field_start_o,
  input logic           field_odd_o,
  input logic [HCW-1:0] h_cnt_o
);
  localparam logic [HCW-1:0] HMAX = {HCW{1'b1}};

  AST_PAIR_SECOND: assert property (@(posedge clk) disable iff (rst)
    (pix_vld_o && !pix_odd_o) |=> (pix_vld_o && pix_odd_o)); // R8

  AST_PAIR_FIRST: assert property (@(posedge clk) disable iff (rst)
    (pix_vld_o && pix_odd_o) |-> $past(pix_vld_o && !pix_odd_o)); // R8

  AST_PAIR_SHARED: assert property (@(posedge clk) disable iff (rst)
    (pix_vld_o && pix_odd_o) |-> ($stable(cb_o) && $stable(cr_o) && $stable(y1_o))); // R8

  AST_LINE_ZERO: assert property (@(posedge clk) disable iff (rst)
    line_start_o |-> (h_cnt_o == '0)); // R2

  AST_LINE_PULSE: assert property (@(posedge clk) disable iff (rst)
    line_start_o |=> !line_start_o); // R2

  AST_HCNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !line_start_o && (h_cnt_o != HMAX)) |-> (h_cnt_o == $past(h_cnt_o) + 1'b1)); // R3

  AST_FIELD_PULSE: assert property (@(posedge clk) disable iff (rst)
    field_start_o |=> !field_start_o); // R5

  AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !field_start_o) |-> $stable(field_odd_o)); // R5
endmodule

bind vrx_top vrx_chk #(.DW(DW), .HCW(HCW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .y1_o          (y1_o),
  .cb_o          (cb_o),
  .cr_o          (cr_o),
  .pix_vld_o     (pix_vld_o),
  .pix_odd_o     (pix_odd_o),
  .line_start_o  (line_start_o),
  .field_start_o (field_start_o),
  .field_odd_o   (field_odd_o),
  .h_cnt_o       (h_cnt_o)
);

// File: tb/tb_vrx_top.sv
module tb_vrx_top;
  localparam int DW  = 8;
  localparam int HCW = 12;
  localparam int VCW = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DW-1:0] din = '0;
  logic vref = 1'b0, href = 1'b0, vact = 1'b0, dval = 1'b0;
  logic [DW-1:0] y0_o, y1_o, y_o, cb_o, cr_o;
  logic pix_vld_o, pix_odd_o, line_start_o, field_start_o, field_odd_o;
  logic [HCW-1:0] h_cnt_o;
  logic [VCW-1:0] v_cnt_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [DW-1:0] m_y [16];
  logic [DW-1:0] m_cb[16];
  logic [DW-1:0] m_cr[16];
  logic          m_od[16];
  int mn = 0;

  always #4 clk = ~clk;

  vrx_top #(.DW(DW), .HCW(HCW), .VCW(VCW)) dut (
    .clk(clk), .rst(rst), .pix_data_i(din), .vref_i(vref), .href_i(href),
    .vact_i(vact), .dval_i(dval), .y0_o(y0_o), .y1_o(y1_o), .y_o(y_o),
    .cb_o(cb_o), .cr_o(cr_o), .pix_vld_o(pix_vld_o), .pix_odd_o(pix_odd_o),
    .line_start_o(line_start_o), .field_start_o(field_start_o),
    .field_odd_o(field_odd_o), .h_cnt_o(h_cnt_o), .v_cnt_o(v_cnt_o)
  );

  // pixel monitor
  always @(negedge clk) begin
    if (pix_vld_o && mn < 16) begin
      m_y[mn]  = y_o;
      m_cb[mn] = cb_o;
      m_cr[mn] = cr_o;
      m_od[mn] = pix_odd_o;
      mn = mn + 1;
    end
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send(logic [DW-1:0] d, logic dv);
    din = d; dval = dv; step();
  endtask

  task automatic chk_pix(int i, int y, int cb, int cr, int od, string req);
    chk(m_y[i] == y[DW-1:0], req, $sformatf("pix%0d y", i), m_y[i], y);
    chk(m_cb[i] == cb[DW-1:0] && m_cr[i] == cr[DW-1:0], req,
        $sformatf("pix%0d cb/cr", i), {m_cb[i], m_cr[i]}, {cb[DW-1:0], cr[DW-1:0]});
    chk(m_od[i] == od[0], req, $sformatf("pix%0d odd", i), m_od[i], od);
  endtask

  task automatic t_reset;
    step(3);
    chk(pix_vld_o == 0 && line_start_o == 0 && field_start_o == 0, "R1", "strobes in reset",
        {pix_vld_o, line_start_o, field_start_o}, 0);
    chk(h_cnt_o == 0 && v_cnt_o == 0 && field_odd_o == 0, "R1", "counters in reset",
        {h_cnt_o, v_cnt_o, field_odd_o}, 0);
    rst = 1'b0;
    step();
    chk(y_o == 0 && cb_o == 0 && cr_o == 0 && pix_vld_o == 0, "R1", "data after reset",
        {y_o, cb_o, cr_o}, 0);
  endtask

  task automatic t_field;
    href = 0; vref = 1; step(2);
    chk(v_cnt_o == 0, "R4", "v_cnt after vref rise", v_cnt_o, 0);
    step();
    href = 1; step(2);
    vref = 0; step(2);
    chk(field_odd_o == 1 && field_start_o == 1, "R5", "odd field at trailing edge",
        {field_odd_o, field_start_o}, 2'b11);
    step();
    chk(field_start_o == 0 && field_odd_o == 1, "R5", "field pulse ends, polarity held",
        {field_odd_o, field_start_o}, 2'b10);
    href = 0; step(2);
    vref = 1; step(3);
    chk(field_odd_o == 1, "R5", "leading edge leaves polarity", field_odd_o, 1);
    vref = 0; step(2);
    chk(field_odd_o == 0 && field_start_o == 1, "R5", "even field at trailing edge",
        {field_odd_o, field_start_o}, 2'b01);
    step(2);
  endtask

  task automatic t_vcnt;
    vref = 1; step(2);
    vref = 0; step();
    for (int k = 0; k < 3; k++) begin
      href = 1; step(3);
      href = 0; step(3);
    end
    chk(v_cnt_o == 3, "R4", "v_cnt after three lines", v_cnt_o, 3);
    vref = 1; step(2);
    chk(v_cnt_o == 0, "R4", "v_cnt cleared by vref rise", v_cnt_o, 0);
    vref = 0; step(2);
  endtask

  task automatic t_hcnt;
    href = 0; step(2);
    href = 1; step(2);
    chk(line_start_o == 1 && h_cnt_o == 0, "R2", "line start at href rise",
        {line_start_o, h_cnt_o}, {1'b1, {HCW{1'b0}}});
    step();
    chk(line_start_o == 0 && h_cnt_o == 1, "R2", "pulse one cycle, count 1",
        {line_start_o, h_cnt_o}, 1);
    vact = 1; step(3);
    vact = 0; step(3);
    chk(h_cnt_o == 7, "R2", "vact fall does not reset h_cnt", h_cnt_o, 7);
    step(4200);
    chk(h_cnt_o == (1 << HCW) - 1, "R3", "h_cnt saturates", h_cnt_o, (1 << HCW) - 1);
  endtask

  task automatic t_locked;
    int vbefore;
    href = 0; step(2);
    href = 1; step();
    vbefore = v_cnt_o + 1;
    mn = 0;
    vact = 1;
    send(8'h80, 1); send(8'h05, 1); send(8'h90, 1); send(8'hFF, 1);
    send(8'h81, 1); send(8'h00, 1); send(8'h91, 1); send(8'h10, 1);
    vact = 0; dval = 0; din = '0;
    step(4);
    chk(mn == 4, "R10", "gapless pixel count", mn, 4);
    chk_pix(0, 8'h05, 8'h80, 8'h90, 0, "R7");
    chk_pix(1, 8'hFF, 8'h80, 8'h90, 1, "R9");
    chk_pix(2, 8'h00, 8'h81, 8'h91, 0, "R9");
    chk_pix(3, 8'h10, 8'h81, 8'h91, 1, "R10");
    chk(y0_o == 8'h00 && y1_o == 8'h10, "R8", "pair luma outputs", {y0_o, y1_o}, 16'h0010);
    chk(v_cnt_o == vbefore[VCW-1:0], "R9", "data values leave v_cnt", v_cnt_o, vbefore);
  endtask

  task automatic t_gaps;
    mn = 0;
    vact = 0;
    send(8'hAA, 1); send(8'hBB, 1); send(8'hCC, 1); send(8'hDD, 1);
    step(2);
    chk(mn == 0, "R6", "no pixels while vact low", mn, 0);
    vact = 1;
    send(8'h20, 1); send(8'hEE, 0); send(8'h30, 1); send(8'hEE, 0);
    send(8'hEE, 0); send(8'h40, 1); send(8'h50, 1);
    dval = 0; step();
    chk(pix_vld_o == 1 && pix_odd_o == 0 && y_o == 8'h30, "R8", "first pixel latency",
        {pix_vld_o, pix_odd_o, y_o}, {2'b10, 8'h30});
    chk(cb_o == 8'h20 && cr_o == 8'h40, "R6", "chroma skips dval-low bytes",
        {cb_o, cr_o}, 16'h2040);
    step();
    chk(pix_vld_o == 1 && pix_odd_o == 1 && y_o == 8'h50, "R8", "second pixel",
        {pix_vld_o, pix_odd_o, y_o}, {2'b11, 8'h50});
    step();
    chk(pix_vld_o == 0, "R8", "strobe ends after pair", pix_vld_o, 0);
    vact = 0; step(2);
    chk(mn == 2, "R6", "pixel count with gaps", mn, 2);
  endtask

  task automatic t_realign;
    mn = 0;
    vact = 1;
    send(8'h11, 1); send(8'h22, 1); send(8'h33, 1);
    vact = 0; dval = 0; step(2);
    vact = 1;
    send(8'h60, 1); send(8'h61, 1); send(8'h62, 1); send(8'h63, 1);
    vact = 0; dval = 0; step(4);
    chk(mn == 2, "R7", "short line yields no pixel", mn, 2);
    chk_pix(0, 8'h61, 8'h60, 8'h62, 0, "R7");
    chk_pix(1, 8'h63, 8'h60, 8'h62, 1, "R7");
  endtask

  initial begin
    t_reset();
    t_field();
    t_vcnt();
    t_hcnt();
    t_locked();
    t_gaps();
    t_realign();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule